// File: doc/BRIEF.md
# Interrupt Pending and In-Service Tracker

This block holds two status bits for every interrupt source of a platform interrupt controller. The first bit is the pending bit, which copies the source's input level on each clock. The second is the in-service bit, which marks a source that a target has taken but not yet finished. An arbiter elsewhere selects which source a target receives. It reports that choice to this block as a one-cycle claim strobe with a source number. Later the target hands the source back with a one-cycle completion strobe and the same number. The arbiter reads both vectors and leaves out any source whose in-service bit is set.

Number 0 is reserved to mean "no source", so bit 0 of each vector is never set. Both vectors come out as whole 32-bit words. Bits past the last real source are padding and read as zero.

Top module: `irq_claim_tracker`

## Requirements
- R1: When no claim names source k (1 <= k < NUM_SRC), pend_vec[k] equals the src_level[k] value sampled at the previous rising clock edge.
- R2: A claim with claim_id = k (1 <= k < NUM_SRC) clears pend_vec[k] and sets srv_vec[k] at the next edge. The claim overrides a high level on that source for that cycle.
- R3: A completion with done_id = k (1 <= k < NUM_SRC) clears srv_vec[k] at the next edge. It has no effect on pend_vec or on any other in-service bit.
- R4: A claim or completion whose ID is NUM_SRC or larger changes neither vector.
- R5: Source 0 is reserved. Bit 0 of pend_vec and bit 0 of srv_vec are always 0, whatever src_level[0] is. A claim or completion with ID 0 is ignored.
- R6: When a claim and a completion name the same source in the same cycle, the claim wins and srv_vec[k] is set. When they name different sources, both take effect.
- R7: Each output is NUM_WORDS 32-bit words. Source k sits at bit 32*(k/32) + (k mod 32), and bits at positions NUM_SRC and above are always 0.
- R8: A synchronous active-high rst clears both vectors at the next edge.
- R9: srv_vec[k] stays set, whatever the level or claim activity on source k, until a completion for k arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_level | input | NUM_SRC | Level from each source; bit 0 is ignored |
| claim_vld | input | 1 | One-cycle claim strobe |
| claim_id | input | ID_W | Source number being claimed |
| done_vld | input | 1 | One-cycle completion strobe |
| done_id | input | ID_W | Source number being completed |
| pend_vec | output | 32*NUM_WORDS | Registered pending bits, word packed |
| srv_vec | output | 32*NUM_WORDS | Registered in-service bits, word packed |

## Verification
The bound checker checks several rules on every clock:
- each pending bit copies its level unless a claim intervenes;
- a claimed source ends up in service and not pending;
- a completion clears its bit unless a claim for the same source collides with it;
- out-of-range completions leave the in-service vector unchanged;
- bit 0 and the padding bits stay at zero;
- reset clears both vectors.

Some behaviour only the bench's scenarios can show. An in-service bit must hold across many cycles while its level toggles. A claim and a completion on different sources, or on the same source, must resolve correctly. Claims landing in the second word must appear at the right bit. All of these also need a long stream of mixed strobes compared against the cycle model.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int unsigned WORD_BITS = 32;

  function automatic int unsigned word_count(input int unsigned n);
    return (n + WORD_BITS - 1) / WORD_BITS;
  endfunction

  function automatic int unsigned id_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irq_id_dec.sv
// Turns an ID strobe into a one-hot hit vector. ID 0 and out-of-range IDs hit nothing.
module irq_id_dec #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ID_W    = 6
) (
  input  logic               vld,
  input  logic [ID_W-1:0]    id,
  output logic [NUM_SRC-1:0] hit
);
  assign hit[0] = 1'b0;
  for (genvar k = 1; k < NUM_SRC; k++) begin : g_hit
    assign hit[k] = vld && (id == ID_W'(k));
  end
endmodule

// File: rtl/irq_trk_word.sv
// One word slice of pending and in-service flops.
module irq_trk_word #(
  parameter int unsigned BITS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BITS-1:0] lvl,
  input  logic [BITS-1:0] clm_hit,
  input  logic [BITS-1:0] done_hit,
  output logic [BITS-1:0] pend_q,
  output logic [BITS-1:0] srv_q
);
  logic [BITS-1:0] pend_d;
  logic [BITS-1:0] srv_d;

  always_comb begin
    // claim overrides the level for pending
    pend_d = lvl & ~clm_hit;
    // claim overrides completion for in-service
    srv_d  = (srv_q & ~done_hit) | clm_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      srv_q  <= '0;
    end else begin
      pend_q <= pend_d;
      srv_q  <= srv_d;
    end
  end
endmodule

// File: rtl/irq_claim_tracker.sv
module irq_claim_tracker #(
  parameter int unsigned NUM_SRC   = 40,
  parameter int unsigned NUM_WORDS = irq_trk_pkg::word_count(NUM_SRC),
  parameter int unsigned ID_W      = irq_trk_pkg::id_width(NUM_SRC)
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [NUM_SRC-1:0]                      src_level,
  input  logic                                    claim_vld,
  input  logic [ID_W-1:0]                         claim_id,
  input  logic                                    done_vld,
  input  logic [ID_W-1:0]                         done_id,
  output logic [irq_trk_pkg::WORD_BITS*NUM_WORDS-1:0] pend_vec,
  output logic [irq_trk_pkg::WORD_BITS*NUM_WORDS-1:0] srv_vec
);
  import irq_trk_pkg::*;

  logic [NUM_SRC-1:0] lvl_m;
  logic [NUM_SRC-1:0] clm_hit;
  logic [NUM_SRC-1:0] done_hit;

  // source 0 is reserved
  assign lvl_m = {src_level[NUM_SRC-1:1], 1'b0};

  irq_id_dec #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_clm_dec (
    .vld(claim_vld), .id(claim_id), .hit(clm_hit)
  );

  irq_id_dec #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_done_dec (
    .vld(done_vld), .id(done_id), .hit(done_hit)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int unsigned LO   = w * WORD_BITS;
    localparam int unsigned BITS = (NUM_SRC - LO > WORD_BITS) ? WORD_BITS : NUM_SRC - LO;

    irq_trk_word #(.BITS(BITS)) u_word (
      .clk      (clk),
      .rst      (rst),
      .lvl      (lvl_m[LO +: BITS]),
      .clm_hit  (clm_hit[LO +: BITS]),
      .done_hit (done_hit[LO +: BITS]),
      .pend_q   (pend_vec[LO +: BITS]),
      .srv_q    (srv_vec[LO +: BITS])
    );

    if (BITS < WORD_BITS) begin : g_pad
      assign pend_vec[LO + BITS +: WORD_BITS - BITS] = '0;
      assign srv_vec[LO + BITS +: WORD_BITS - BITS]  = '0;
    end
  end
endmodule

// File: rtl/irq_claim_tracker_chk.sv
module irq_claim_tracker_chk #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned OUT_W   = 64,
  parameter int unsigned ID_W    = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_level,
  input logic               claim_vld,
  input logic [ID_W-1:0]    claim_id,
  input logic               done_vld,
  input logic [ID_W-1:0]    done_id,
  input logic [OUT_W-1:0]   pend_vec,
  input logic [OUT_W-1:0]   srv_vec
);
  logic clm_ok, done_ok;
  assign clm_ok  = claim_vld && (claim_id != '0) && (32'(claim_id) < NUM_SRC);
  assign done_ok = done_vld && (done_id != '0) && (32'(done_id) < NUM_SRC);

  a_r1_follow_level: assert property (@(posedge clk) disable iff (rst)
    (!rst && !claim_vld) |=> pend_vec[NUM_SRC-1:1] == $past(src_level[NUM_SRC-1:1]));

  a_r2_claim_sets: assert property (@(posedge clk) disable iff (rst)
    (!rst && clm_ok) |=> (srv_vec[$past(claim_id)] && !pend_vec[$past(claim_id)]));

  a_r3_done_clears: assert property (@(posedge clk) disable iff (rst)
    (!rst && done_ok && !(claim_vld && claim_id == done_id)) |=> !srv_vec[$past(done_id)]);

  a_r4_oor_done: assert property (@(posedge clk) disable iff (rst)
    (!rst && done_vld && 32'(done_id) >= NUM_SRC && !claim_vld) |=> srv_vec == $past(srv_vec));

  a_r5_src0_zero: assert property (@(posedge clk) !pend_vec[0] && !srv_vec[0]);

  a_r7_pad_zero: assert property (@(posedge clk)
    (pend_vec >> NUM_SRC) == '0 && (srv_vec >> NUM_SRC) == '0);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (pend_vec == '0 && srv_vec == '0));
endmodule

bind irq_claim_tracker irq_claim_tracker_chk #(
  .NUM_SRC(NUM_SRC), .OUT_W(irq_trk_pkg::WORD_BITS*NUM_WORDS), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst(rst), .src_level(src_level),
  .claim_vld(claim_vld), .claim_id(claim_id),
  .done_vld(done_vld), .done_id(done_id),
  .pend_vec(pend_vec), .srv_vec(srv_vec)
);

// File: tb/sim_irq_claim_tracker.sv
module sim_irq_claim_tracker;
  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] lvl = '0;
  logic        cv = 1'b0;
  logic [5:0]  cid = '0;
  logic        dv = 1'b0;
  logic [5:0]  did = '0;
  logic [63:0] pend, srv;
  logic [63:0] pm = '0, sm = '0;
  int vectors = 0, miscompares = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  irq_claim_tracker u0 (
    .clk(clk), .rst(rst), .src_level(lvl),
    .claim_vld(cv), .claim_id(cid), .done_vld(dv), .done_id(did),
    .pend_vec(pend), .srv_vec(srv)
  );

  // behavioural reference, evaluated once per rising edge
  task automatic model_step();
    if (rst) begin
      pm = '0; sm = '0;
    end else begin
      for (int k = 1; k < N; k++) begin
        pm[k] = lvl[k];
        if (dv && int'(did) == k) sm[k] = 1'b0;
        if (cv && int'(cid) == k) begin pm[k] = 1'b0; sm[k] = 1'b1; end
      end
    end
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    vectors++;
    if (pend !== pm || srv !== sm) begin
      miscompares++;
      $display("FAIL %s pend got %h exp %h, srv got %h exp %h", req, pend, pm, srv, sm);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog got timeout exp finish");
    finish_run();
  end

  initial begin
    cyc("R8");                                   // reset state
    rst = 1'b0;
    lvl = 40'h00_0000_00F6; cyc("R1");
    lvl = 40'hFF_0000_0001; cyc("R5");           // bit 0 level ignored, padding zero R7
    lvl = 40'h00_0000_0020; cv = 1; cid = 6'd5; cyc("R2");
    cv = 0; cyc("R9");                           // level high again, still in service
    lvl = '0; cyc("R9");
    cv = 1; cid = 6'd0; cyc("R5");
    lvl = 40'h20_0000_0000; cid = 6'd45; cyc("R4");
    cv = 0; dv = 1; did = 6'd45; cyc("R4");
    dv = 0; cv = 1; cid = 6'd33; lvl = 40'h02_0000_0020; cyc("R7");
    cv = 0; dv = 1; did = 6'd5; cyc("R3");       // pending of 5 stays with level
    dv = 1; did = 6'd0; cyc("R5");
    cv = 1; cid = 6'd33; did = 6'd33; cyc("R6");
    cid = 6'd7; did = 6'd33; cyc("R6");
    cv = 0; dv = 0; cyc("R9");
    rst = 1; cyc("R8");
    rst = 0; cyc("R8");
    for (int i = 0; i < 400; i++) begin
      lvl = {$urandom, $urandom};
      cv  = ($urandom % 3) == 0;
      cid = 6'($urandom);
      dv  = ($urandom % 3) == 0;
      did = ($urandom % 4 == 0) ? cid : 6'($urandom);
      cyc("R1");
    end
    finish_run();
  end
endmodule